// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block keeps the 8-bit device status byte of a serial EEPROM, together with its write-enable latch. It decides whether a status-register write may go ahead and whether a given array address may be programmed. The serial front end gives it decoded strobes: write-enable set and clear, a status-write request with its data byte, and a level that shows a status-write byte is still being shifted in. The front end also passes in the raw active-low write-protect pin. The array engine supplies its busy level and an end-of-cycle strobe.

Protection has two levels. The WPBEN bit decides whether the pin counts. The pin, when it counts, locks the status register, including WPBEN itself. The two block-protect bits then lock the top quarter, the top half or all of the array against programming. An accepted status write starts its own busy cycle. The end-of-cycle strobe closes that cycle and drops the write-enable latch.

Top module: `sr_wp_ctrl`

## Requirements
- R1: The status byte is laid out as bit 7 WPBEN, bits 6..4 always 0, bit 3 BP1, bit 2 BP0, bit 1 WEN, bit 0 not-ready. After reset it reads 0x00.
- R2: BP1:BP0 select the locked array range for an 18-bit address. 00 locks nothing, 01 locks 0x30000..0x3FFFF, 10 locks 0x20000..0x3FFFF, and 11 locks every address.
- R3: A write-enable set strobe sets WEN and a clear strobe clears it, whatever the level of wp_n_i. Clear wins when both arrive together. WEN is 0 after reset.
- R4: A status-write request is accepted only when WEN is 1, no cycle is busy, and either wp_n_i is high or WPBEN is 0. Acceptance gives a one-cycle sr_wr_ok_o pulse in the cycle after the request.
- R5: While wp_n_i is low and WPBEN is 1, every status write is refused, so WPBEN stays 1.
- R6: If wp_n_i goes low while WPBEN is 1 and sr_shift_i is high, the request that ends that shift is refused, even if the pin has risen again. Once a request is accepted, the pin has no effect on it.
- R7: While a status-write cycle or an array cycle (array_busy_i) is running, bits 0 and 1 both read 1.
- R8: An accepted status write copies data bits 7, 3 and 2 only, and reserved bits read 0. It holds bit 0 at 1 until cycle_done_i. A cycle_done_i during any busy cycle clears WEN.
- R9: arr_wr_ok_o is 1 only when WEN is 1 and arr_addr_i lies outside the range that BP1:BP0 select. It follows arr_addr_i in the same cycle.
- R10: While any cycle is busy, set strobes, clear strobes and status-write requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen_set_i | input | 1 | Write-enable set strobe |
| wen_clr_i | input | 1 | Write-enable clear strobe |
| sr_shift_i | input | 1 | High while a status-write data byte is being received |
| sr_wr_req_i | input | 1 | Status-write request strobe |
| sr_wr_data_i | input | 8 | Status byte that comes with the request |
| wp_n_i | input | 1 | Write-protect pin, active low |
| array_busy_i | input | 1 | Array programming cycle in progress |
| cycle_done_i | input | 1 | End-of-internal-cycle strobe |
| arr_addr_i | input | 18 | Candidate array address |
| status_o | output | 8 | Status byte for reading |
| arr_wr_ok_o | output | 1 | Array write allowed at arr_addr_i |
| sr_wr_ok_o | output | 1 | Status write accepted (one-cycle pulse) |

## Verification
Every strobe and request takes effect on the clock edge that samples it. The status byte and sr_wr_ok_o therefore show the result one edge after the stimulus. arr_wr_ok_o is combinational in arr_addr_i, and changes in it show in the same cycle. The bench drives inputs just after a rising edge, steps exactly one edge, and samples a little after it. Address checks are sampled before the next edge, with no extra edge in between.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
    localparam int SR_W   = 8;
    localparam int B_WPEN = 7;
    localparam int B_BP1  = 3;
    localparam int B_BP0  = 2;
    localparam int B_WEN  = 1;
    localparam int B_BSY  = 0;

    typedef struct packed {
        logic       wpben;
        logic [1:0] bp;
        logic       wen;
        logic       busy;   // status-write cycle running
        logic       abort;  // pin dipped during the shift
        logic       ok;     // acceptance pulse
    } sr_state_t;
endpackage

// File: rtl/sr_wp_range.sv
module sr_wp_range #(
    parameter int ADDR_W = 18
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] seg;
    assign seg = addr_i[TOP -: 2];

    always_comb begin
        unique case (bp_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = (seg == 2'b11);
            2'b10:   locked_o = seg[1];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_wp_gate.sv
module sr_wp_gate (
    input  logic req_i,
    input  logic wen_i,
    input  logic busy_i,
    input  logic wp_n_i,
    input  logic wpben_i,
    input  logic abort_q_i,
    input  logic shift_i,
    output logic grant_o,
    output logic abort_d_o
);
    logic pin_lock;
    assign pin_lock  = !wp_n_i && wpben_i;
    assign grant_o   = req_i && wen_i && !busy_i && !pin_lock && !abort_q_i;
    assign abort_d_o = shift_i && !req_i && (abort_q_i || pin_lock);
endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
    import sr_wp_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              sr_shift_i,
    input  logic              sr_wr_req_i,
    input  logic [SR_W-1:0]   sr_wr_data_i,
    input  logic              wp_n_i,
    input  logic              array_busy_i,
    input  logic              cycle_done_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    output logic [SR_W-1:0]   status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    sr_state_t st_q, st_d;
    logic      busy_any, grant, abort_d, locked;
    logic      unused_data;

    assign busy_any    = st_q.busy || array_busy_i;
    assign unused_data = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0]};

    sr_wp_gate u_gate (
        .req_i     (sr_wr_req_i),
        .wen_i     (st_q.wen),
        .busy_i    (busy_any),
        .wp_n_i    (wp_n_i),
        .wpben_i   (st_q.wpben),
        .abort_q_i (st_q.abort),
        .shift_i   (sr_shift_i),
        .grant_o   (grant),
        .abort_d_o (abort_d)
    );

    sr_wp_range #(.ADDR_W(ADDR_W)) u_range (
        .bp_i     (st_q.bp),
        .addr_i   (arr_addr_i),
        .locked_o (locked)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ok    = 1'b0;
        st_d.abort = abort_d;
        if (!busy_any) begin
            if (wen_set_i) st_d.wen = 1'b1;
            if (wen_clr_i) st_d.wen = 1'b0;
        end
        if (grant) begin
            st_d.wpben = sr_wr_data_i[B_WPEN];
            st_d.bp    = {sr_wr_data_i[B_BP1], sr_wr_data_i[B_BP0]};
            st_d.busy  = 1'b1;
            st_d.ok    = 1'b1;
        end
        if (cycle_done_i && busy_any) begin
            st_d.busy = 1'b0;
            st_d.wen  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o         = '0;
        status_o[B_WPEN] = st_q.wpben;
        status_o[B_BP1]  = st_q.bp[1];
        status_o[B_BP0]  = st_q.bp[0];
        status_o[B_BSY]  = busy_any;
        status_o[B_WEN]  = st_q.wen || busy_any;
    end

    assign arr_wr_ok_o = st_q.wen && !locked;
    assign sr_wr_ok_o  = st_q.ok;
endmodule

// File: rtl/sr_wp_ctrl_chk.sv
module sr_wp_ctrl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wen_clr_i,
    input logic              wp_n_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic [7:0]        status_o,
    input logic              arr_wr_ok_o,
    input logic              sr_wr_ok_o
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    a_r2_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b11 |-> !arr_wr_ok_o);

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clr_i && !status_o[0] |=> !status_o[1] || status_o[0]);

    a_r4_accept_rule: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok_o |-> $past(status_o[1]) && !$past(status_o[0])
                       && ($past(wp_n_i) || !$past(status_o[7])));

    a_r5_wpben_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i && status_o[7] |=> status_o[7]);

    a_r7_busy_reads_wen: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> status_o[1]);

    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok_o |-> status_o[0]);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok_o |=> !sr_wr_ok_o);

    a_r9_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok_o |-> status_o[1]);

    a_r2_top_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b01 && arr_addr_i[ADDR_W-1 -: 2] == 2'b11 |-> !arr_wr_ok_o);
endmodule

bind sr_wp_ctrl sr_wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wen_clr_i   (wen_clr_i),
    .wp_n_i      (wp_n_i),
    .arr_addr_i  (arr_addr_i),
    .status_o    (status_o),
    .arr_wr_ok_o (arr_wr_ok_o),
    .sr_wr_ok_o  (sr_wr_ok_o)
);

// File: tb/sr_wp_ctrl_bench.sv
module sr_wp_ctrl_bench;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_set_i = 1'b0, wen_clr_i = 1'b0, sr_shift_i = 1'b0, sr_wr_req_i = 1'b0;
    logic [7:0]    sr_wr_data_i = '0;
    logic          wp_n_i = 1'b1, array_busy_i = 1'b0, cycle_done_i = 1'b0;
    logic [AW-1:0] arr_addr_i = '0;
    logic [7:0]    status_o;
    logic          arr_wr_ok_o, sr_wr_ok_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sr_wp_ctrl #(.ADDR_W(AW)) u_sr_wp_ctrl (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_wen();
        wen_set_i = 1'b1; tick(); wen_set_i = 1'b0;
    endtask

    task automatic clr_wen();
        wen_clr_i = 1'b1; tick(); wen_clr_i = 1'b0;
    endtask

    task automatic finish_cycle();
        cycle_done_i = 1'b1; tick(); cycle_done_i = 1'b0;
    endtask

    task automatic sr_write(logic [7:0] d, logic exp_ok, string req);
        sr_wr_data_i = d; sr_wr_req_i = 1'b1; tick(); sr_wr_req_i = 1'b0;
        check(req, sr_wr_ok_o, exp_ok);
    endtask

    task automatic addr_ok(logic [AW-1:0] a, logic exp, string req);
        arr_addr_i = a; #1;
        check(req, arr_wr_ok_o, exp);
    endtask

    task automatic t_reset();
        check("R1 reset status", status_o, 8'h00);
        check("R3 reset wen", arr_wr_ok_o, 1'b0);
        check("R4 reset pulse", sr_wr_ok_o, 1'b0);
    endtask

    task automatic t_wen();
        wp_n_i = 1'b0;
        set_wen();  check("R3 set with pin low", status_o, 8'h02);
        clr_wen();  check("R3 clear", status_o, 8'h00);
        set_wen();
        wen_set_i = 1'b1; wen_clr_i = 1'b1; tick(); wen_set_i = 1'b0; wen_clr_i = 1'b0;
        check("R3 clear wins", status_o, 8'h00);
    endtask

    task automatic t_fields();
        sr_write(8'h8C, 1'b0, "R4 refused without wen");
        check("R4 unchanged", status_o, 8'h00);
        set_wen();
        sr_write(8'hFF, 1'b1, "R4 accepted pin low wpben 0");
        check("R7 R8 busy view", status_o, 8'h8F);
        tick();
        check("R4 pulse one cycle", sr_wr_ok_o, 1'b0);
        finish_cycle();
        check("R8 fields and wen cleared", status_o, 8'h8C);
    endtask

    task automatic t_lock();
        set_wen();
        check("R5 wen set", status_o, 8'h8E);
        sr_write(8'h00, 1'b0, "R5 refused while locked");
        check("R5 wpben kept", status_o, 8'h8E);
        wp_n_i = 1'b1;
        sr_write(8'h04, 1'b1, "R4 accepted pin high");
        finish_cycle();
        check("R8 bp01", status_o, 8'h04);
    endtask

    task automatic t_ranges();
        set_wen();
        addr_ok(18'h2FFFF, 1'b1, "R2 R9 quarter below");
        addr_ok(18'h30000, 1'b0, "R2 quarter start");
        addr_ok(18'h3FFFF, 1'b0, "R2 quarter end");
        sr_write(8'h08, 1'b1, "R4 bp10 write");
        finish_cycle(); set_wen();
        addr_ok(18'h1FFFF, 1'b1, "R2 half below");
        addr_ok(18'h20000, 1'b0, "R2 half start");
        sr_write(8'h0C, 1'b1, "R4 bp11 write");
        finish_cycle(); set_wen();
        addr_ok(18'h00000, 1'b0, "R2 all locked");
        sr_write(8'h00, 1'b1, "R4 bp00 write");
        finish_cycle(); set_wen();
        addr_ok(18'h3FFFF, 1'b1, "R2 R9 none locked");
        clr_wen();
        addr_ok(18'h3FFFF, 1'b0, "R9 needs wen");
    endtask

    task automatic t_abort();
        set_wen();
        sr_write(8'h80, 1'b1, "R4 set wpben");
        finish_cycle(); set_wen();
        sr_shift_i = 1'b1; tick();
        wp_n_i = 1'b0; tick();
        wp_n_i = 1'b1; tick();
        sr_shift_i = 1'b0;
        sr_write(8'h84, 1'b0, "R6 dip aborts");
        check("R6 unchanged", status_o, 8'h82);
        sr_shift_i = 1'b1; tick(); tick(); sr_shift_i = 1'b0;
        sr_write(8'h84, 1'b1, "R6 clean shift accepted");
        wp_n_i = 1'b0; tick();
        finish_cycle();
        check("R6 pin after accept no effect", status_o, 8'h84);
        wp_n_i = 1'b1;
    endtask

    task automatic t_busy();
        set_wen();
        array_busy_i = 1'b1; tick();
        check("R7 array busy view", status_o, 8'h87);
        clr_wen();
        sr_write(8'h00, 1'b0, "R10 request while busy");
        array_busy_i = 1'b0; tick();
        check("R10 wen and fields kept", status_o, 8'h86);
        array_busy_i = 1'b1;
        finish_cycle();
        array_busy_i = 1'b0; #1;
        check("R8 array end clears wen", status_o, 8'h84);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_wen();
        t_fields();
        t_lock();
        t_ranges();
        t_abort();
        t_busy();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule